// File: doc/BRIEF.md
# Dual-Channel PDM Sinc3 Decimator

This block turns two single-bit pulse-density microphone streams into signed 16-bit PCM samples. The two streams are a reference channel and an error channel. It divides the system clock down to make the microphone bit clock. Each bit that comes back is read as +1 or −1. Each channel then passes its bits through three cascaded integrators and three comb sections with differential delay 64. This gives the third-order sinc response ((1 − z^−64)/(1 − z^−1))^3.

Once every 64 bits, each channel scales its comb result down to 16 bits, clamps it, and presents the new sample with a one-cycle strobe. Both channels share one bit clock and one decimation phase, so their samples appear in the same cycle. The block is placed between the microphone pins and a downstream audio processor that accepts one PCM word per channel per strobe.

Top module: `pdm_sinc3_dual`

## Requirements
- R1: `pdm_clk_o` has a period of 32 system clocks with 16 cycles high and 16 low. It sits high while reset is held, and the first cycle after reset is the first cycle of a high phase.
- R2: Each data input is captured at the system clock edge where `pdm_clk_o` goes from low to high. A captured 1 counts as +1 and a captured 0 counts as −1.
- R3: Each channel emits one sample per 64 captured bits. Its strobe is high for exactly one cycle, starting at the edge that captures the 64th bit. Consecutive strobes are 2048 system clocks apart, and the first strobe comes 2048 clocks after reset release.
- R4: Before scaling, a sample equals the FIR response of the ±1 sequence to the coefficients of ((1 − z^−64)/(1 − z^−1))^3, which has 190 taps. All bits before reset release count as zero.
- R5: The unscaled result is shifted right by 3 bits arithmetically, rounding toward minus infinity. A steady stream of 0 bits therefore settles at −32768.
- R6: A scaled value above 32767 is clamped to 32767, and one below −32768 is clamped to −32768. A steady stream of 1 bits therefore settles at 32767.
- R7: Each channel's samples depend only on its own data input. The two strobes occur in the same cycle.
- R8: Synchronous active-low reset clears all filter state, the bit-clock divider and the decimation counter. While reset is held, both PCM outputs read 0 and both strobes are low.
- R9: A PCM output changes only in a cycle where its strobe is high. It holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_bit_i | input | 1 | Reference microphone bitstream |
| err_bit_i | input | 1 | Error microphone bitstream |
| pdm_clk_o | output | 1 | Microphone bit clock (system clock / 32) |
| ref_pcm_o | output | 16 | Reference PCM sample, two's complement |
| ref_vld_o | output | 1 | Reference sample strobe |
| err_pcm_o | output | 16 | Error PCM sample, two's complement |
| err_vld_o | output | 1 | Error sample strobe |

## Verification
The checks assume that reset is held low from time zero until the divider and the filter registers have been cleared. They also assume that each data input is settled before the system edge on which `pdm_clk_o` rises. The stimulus meets both conditions. It holds reset low from the first instant, and it changes both data inputs only on a falling system-clock edge that follows the fall of `pdm_clk_o`, which is half a bit period before the capturing edge. The bit patterns are:
- steady ones, to reach the positive clamp
- steady zeros, to reach the exact negative limit
- opposite alternation on the two channels
- pseudo-random bits against a three-quarter-density stream
- a reset in the middle of a frame

Reference values come from a direct 190-tap convolution of the stored bit history.

// File: rtl/pdm_sinc3_pkg.sv
// Shared constants and width helpers for the dual PDM sinc3 decimator.
// Assumes the decimation ratio is a power of two.
package pdm_sinc3_pkg;
    localparam int unsigned STAGES = 3;

    // Accumulator width: sign + growth of STAGES*log2(ratio) + one bit for the +ratio^3 extreme
    function automatic int unsigned acc_width(input int unsigned decim);
        return 2 + STAGES * $clog2(decim);
    endfunction
endpackage

// File: rtl/pdm_clk_div.sv
// Divides the system clock into the microphone bit clock and flags the
// system cycle whose closing edge captures a data bit (bit clock rising).
// Assumes DIV is even and at least 2.
module pdm_clk_div #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic pdm_clk_o,
    output logic bit_tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] phase_q;

    // Free-running phase counter, restarted by reset
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign pdm_clk_o  = (phase_q < HALF);
    assign bit_tick_o = (phase_q == LAST);
endmodule

// File: rtl/pdm_decim_seq.sv
// Counts captured bits and flags the capture edge of every DECIM-th bit,
// on which both channels run their comb sections.
// Assumes bit_tick_i is a single-cycle pulse.
module pdm_decim_seq #(
    parameter int unsigned DECIM = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick_i,
    output logic dump_o
);
    localparam int unsigned CW = (DECIM > 2) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

    logic [CW-1:0] bit_cnt_q;

    // Bit counter within one decimation frame
    always_ff @(posedge clk) begin
        if (!rst_n)                                bit_cnt_q <= '0;
        else if (bit_tick_i && bit_cnt_q == LAST)  bit_cnt_q <= '0;
        else if (bit_tick_i)                       bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    assign dump_o = bit_tick_i && (bit_cnt_q == LAST);
endmodule

// File: rtl/pdm_pcm_clamp.sv
// Scales a wide signed comb result down by an arithmetic right shift and
// clamps it into a signed OUT_W-bit word. Purely combinational.
// Assumes IN_W - SHIFT >= OUT_W.
module pdm_pcm_clamp #(
    parameter int unsigned IN_W  = 20,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned SHIFT = 3
) (
    input  logic signed [IN_W-1:0]  wide_i,
    output logic        [OUT_W-1:0] pcm_o
);
    localparam logic signed [IN_W-1:0] TOP = IN_W'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic signed [IN_W-1:0] BOT = ~TOP;

    logic signed [IN_W-1:0] scaled;

    assign scaled = wide_i >>> SHIFT;

    // Clamp the scaled value to the output range
    always_comb begin
        if (scaled > TOP)      pcm_o = TOP[OUT_W-1:0];
        else if (scaled < BOT) pcm_o = BOT[OUT_W-1:0];
        else                   pcm_o = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/pdm_sinc3_chan.sv
// One sinc3 decimation channel: cascaded integrators run on every captured
// bit, cascaded combs run once per frame, then scale, clamp and register.
// Assumes dump_i is only high together with bit_tick_i. Wrap-around in the
// integrators is intended; the comb output is exact modulo 2^ACC_W.
module pdm_sinc3_chan #(
    parameter int unsigned DECIM = 64,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick_i,
    input  logic             dump_i,
    input  logic             pdm_i,
    output logic [OUT_W-1:0] pcm_o,
    output logic             valid_o
);
    import pdm_sinc3_pkg::*;

    localparam int unsigned ACC_W = acc_width(DECIM);
    localparam int unsigned SHIFT = ACC_W - 1 - OUT_W;

    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t PLUS_ONE  = acc_t'(1);
    localparam acc_t MINUS_ONE = '1;

    acc_t integ_q [STAGES];
    acc_t integ_d [STAGES];
    acc_t dly_q   [STAGES];
    acc_t comb_d  [STAGES];
    logic [OUT_W-1:0] pcm_d;

    // Next integrator values: the first takes the mapped bit, each later one its predecessor
    always_comb begin
        integ_d[0] = integ_q[0] + (pdm_i ? PLUS_ONE : MINUS_ONE);
        for (int s = 1; s < STAGES; s++)
            integ_d[s] = integ_q[s] + integ_d[s-1];
    end

    // Comb chain differences against the values held at the previous frame
    always_comb begin
        comb_d[0] = integ_d[STAGES-1] - dly_q[0];
        for (int s = 1; s < STAGES; s++)
            comb_d[s] = comb_d[s-1] - dly_q[s];
    end

    pdm_pcm_clamp #(
        .IN_W (ACC_W),
        .OUT_W(OUT_W),
        .SHIFT(SHIFT)
    ) u_clamp (
        .wide_i(comb_d[STAGES-1]),
        .pcm_o (pcm_d)
    );

    // Filter state: integrators per bit, comb delays per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                integ_q[s] <= '0;
                dly_q[s]   <= '0;
            end
        end else begin
            if (bit_tick_i) begin
                for (int s = 0; s < STAGES; s++)
                    integ_q[s] <= integ_d[s];
            end
            if (dump_i) begin
                dly_q[0] <= integ_d[STAGES-1];
                for (int s = 1; s < STAGES; s++)
                    dly_q[s] <= comb_d[s-1];
            end
        end
    end

    // Output register and one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= dump_i;
            if (dump_i) pcm_o <= pcm_d;
        end
    end
endmodule

// File: rtl/pdm_sinc3_dual.sv
// Top level: one bit-clock divider and one frame counter shared by a
// reference and an error sinc3 channel.
// Assumes the data inputs are synchronous to clk and settled before the
// edge at which pdm_clk_o rises.
module pdm_sinc3_dual #(
    parameter int unsigned CLK_DIV = 32,
    parameter int unsigned DECIM   = 64,
    parameter int unsigned PCM_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_bit_i,
    input  logic             err_bit_i,
    output logic             pdm_clk_o,
    output logic [PCM_W-1:0] ref_pcm_o,
    output logic             ref_vld_o,
    output logic [PCM_W-1:0] err_pcm_o,
    output logic             err_vld_o
);
    localparam int unsigned NCH = 2;

    logic             bit_tick;
    logic             dump;
    logic [NCH-1:0]   bits_in;
    logic [PCM_W-1:0] pcm [NCH];
    logic [NCH-1:0]   vld;

    assign bits_in = {err_bit_i, ref_bit_i};

    pdm_clk_div #(.DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdm_clk_o (pdm_clk_o),
        .bit_tick_o(bit_tick)
    );

    pdm_decim_seq #(.DECIM(DECIM)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick_i(bit_tick),
        .dump_o    (dump)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pdm_sinc3_chan #(
            .DECIM(DECIM),
            .OUT_W(PCM_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_tick_i(bit_tick),
            .dump_i    (dump),
            .pdm_i     (bits_in[c]),
            .pcm_o     (pcm[c]),
            .valid_o   (vld[c])
        );
    end

    assign ref_pcm_o = pcm[0];
    assign ref_vld_o = vld[0];
    assign err_pcm_o = pcm[1];
    assign err_vld_o = vld[1];
endmodule

// File: rtl/pdm_sinc3_dual_chk.sv
// Property checker for pdm_sinc3_dual, attached by bind below.
// Assumes rst_n is low from time zero until the first clock edge.
module pdm_sinc3_dual_chk #(
    parameter int unsigned CLK_DIV = 32,
    parameter int unsigned PCM_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pdm_clk_o,
    input logic [PCM_W-1:0] ref_pcm_o,
    input logic             ref_vld_o,
    input logic [PCM_W-1:0] err_pcm_o,
    input logic             err_vld_o
);
    logic pdm_prev_q;
    logic seen_rise_q;
    int   since_rise_q;
    logic rise;

    assign rise = pdm_clk_o && !pdm_prev_q;

    // Track the spacing between bit-clock rising edges
    always_ff @(posedge clk) begin
        pdm_prev_q <= pdm_clk_o;
        if (!rst_n) begin
            seen_rise_q  <= 1'b0;
            since_rise_q <= 0;
        end else begin
            seen_rise_q  <= seen_rise_q | rise;
            since_rise_q <= rise ? 0 : since_rise_q + 1;
        end
    end

    p_pdm_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_rise_q) |-> (since_rise_q == int'(CLK_DIV) - 1));

    p_ref_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_vld_o |=> !ref_vld_o);

    p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld_o |=> !err_vld_o);

    p_vld_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_vld_o |-> $rose(pdm_clk_o));

    p_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_vld_o |-> err_vld_o);

    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_vld_o |-> $stable(ref_pcm_o));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld_o |-> $stable(err_pcm_o));
endmodule

bind pdm_sinc3_dual pdm_sinc3_dual_chk #(
    .CLK_DIV(CLK_DIV),
    .PCM_W  (PCM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdm_clk_o(pdm_clk_o),
    .ref_pcm_o(ref_pcm_o),
    .ref_vld_o(ref_vld_o),
    .err_pcm_o(err_pcm_o),
    .err_vld_o(err_vld_o)
);

// File: tb/pdm_sinc3_dual_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected samples, the monitor pops and compares.
module pdm_sinc3_dual_bench;
    localparam int R     = 64;
    localparam int KLEN  = 3 * R - 2;
    localparam int FRAME = 32 * R;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_bit = 1'b0;
    logic        err_bit = 1'b0;
    logic        pdm_clk;
    logic [15:0] ref_pcm, err_pcm;
    logic        ref_vld, err_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int    h [KLEN];
    int    hist_ref [$];
    int    hist_err [$];
    int    exp_ref [$];
    int    exp_err [$];
    string tag_ref [$];
    string tag_err [$];
    int    last_ref, last_err;
    int    held_ref, held_err;
    bit    prev_ref_vld, prev_err_vld;
    int    hold_bad;
    logic [15:0] lfsr = 16'hACE1;

    pdm_sinc3_dual u_pdm_sinc3_dual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_bit_i(ref_bit),
        .err_bit_i(err_bit),
        .pdm_clk_o(pdm_clk),
        .ref_pcm_o(ref_pcm),
        .ref_vld_o(ref_vld),
        .err_pcm_o(err_pcm),
        .err_vld_o(err_vld)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Direct 190-tap sinc3 convolution of a channel's history, then scale and clamp
    function automatic int model(input int ch);
        int n;
        int acc;
        int s;
        n = (ch == 0) ? hist_ref.size() - 1 : hist_err.size() - 1;
        acc = 0;
        for (int k = 0; k < KLEN; k++) begin
            if (n - k >= 0)
                acc += h[k] * ((ch == 0) ? hist_ref[n-k] : hist_err[n-k]);
        end
        s = acc >>> 3;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // Driver: one bit per bit-clock period, changed after the bit clock falls
    task automatic run_bits(input int n, input int mode, input string tag);
        for (int i = 0; i < n; i++) begin
            bit br;
            bit be;
            int idx;
            @(negedge pdm_clk);
            @(negedge clk);
            idx = hist_ref.size();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin br = 1; be = 1; end
                1: begin br = 0; be = 0; end
                2: begin br = idx[0]; be = !idx[0]; end
                3: begin br = lfsr[0]; be = (idx % 4) != 0; end
                default: begin br = lfsr[3]; be = lfsr[9]; end
            endcase
            ref_bit = br;
            err_bit = be;
            hist_ref.push_back(br ? 1 : -1);
            hist_err.push_back(be ? 1 : -1);
            if (hist_ref.size() % R == 0) begin
                exp_ref.push_back(model(0));
                exp_err.push_back(model(1));
                tag_ref.push_back(tag);
                tag_err.push_back(tag);
            end
        end
    endtask

    // R1: bit clock duty and rising-edge count over two periods after release
    task automatic measure_clk();
        int highs = 0;
        int rises = 0;
        logic prev = 1'b1;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pdm_clk) highs++;
            if (pdm_clk && !prev) rises++;
            prev = pdm_clk;
        end
        check("R1 high cycles", highs, 32);
        check("R1 rising edges", rises, 2);
    endtask

    // Monitor: pop expected samples on each strobe, check spacing and holding
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ref_vld) begin
                if (exp_ref.size() == 0) begin
                    check("R3 unexpected ref strobe", 1, 0);
                end else begin
                    check({tag_ref.pop_front(), " ref"}, int'($signed(ref_pcm)), exp_ref.pop_front());
                end
                check("R3 ref spacing", cyc - last_ref, FRAME);
                check("R7 err strobe together", int'(err_vld), 1);
                last_ref = cyc;
                held_ref = int'(ref_pcm);
            end else if (int'(ref_pcm) != held_ref) begin
                hold_bad++;
            end
            if (err_vld) begin
                if (exp_err.size() == 0) begin
                    check("R3 unexpected err strobe", 1, 0);
                end else begin
                    check({tag_err.pop_front(), " err"}, int'($signed(err_pcm)), exp_err.pop_front());
                end
                last_err = cyc;
                held_err = int'(err_pcm);
            end else if (int'(err_pcm) != held_err) begin
                hold_bad++;
            end
            if (ref_vld && prev_ref_vld) check("R3 ref strobe width", 2, 1);
            if (err_vld && prev_err_vld) check("R3 err strobe width", 2, 1);
            prev_ref_vld = ref_vld;
            prev_err_vld = err_vld;
        end
    end

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        hist_ref.delete();
        hist_err.delete();
        last_ref = cyc;
        last_err = cyc;
        held_ref = 0;
        held_err = 0;
        prev_ref_vld = 0;
        prev_err_vld = 0;
    endtask

    initial begin
        for (int k = 0; k < KLEN; k++) h[k] = 0;
        for (int a = 0; a < R; a++)
            for (int b = 0; b < R; b++)
                for (int c = 0; c < R; c++)
                    h[a+b+c]++;
        hold_bad = 0;
        repeat (4) @(negedge clk);
        check("R8 ref pcm in reset", int'(ref_pcm), 0);
        check("R8 strobes in reset", int'(ref_vld) + int'(err_vld), 0);
        check("R1 bit clock high in reset", int'(pdm_clk), 1);
        release_reset();
        fork
            measure_clk();
        join_none
        run_bits(5 * R, 0, "R6 steady ones clamp");
        run_bits(5 * R, 1, "R5 steady zeros scaling");
        run_bits(4 * R, 2, "R2 opposite alternation");
        run_bits(16 * R + 30, 3, "R7 independent channels");
        repeat (40) @(negedge clk);
        check("R3 all ref samples seen", exp_ref.size(), 0);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 ref pcm cleared", int'(ref_pcm), 0);
        check("R8 err pcm cleared", int'(err_pcm), 0);
        check("R8 strobes low", int'(ref_vld) + int'(err_vld), 0);
        release_reset();
        run_bits(7 * R, 4, "R8 R4 random after reset");
        repeat (60) @(negedge clk);
        check("R3 ref queue drained", exp_ref.size(), 0);
        check("R3 err queue drained", exp_err.size(), 0);
        check("R9 outputs held between strobes", hold_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule